// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight asynchronous interrupt pins and turns activity on them into interrupt requests for a parent interrupt controller. Each pin has a sense field that selects one of five detection modes: falling edge, rising edge, low level, high level or both edges. A detected event sets the pin's pending bit. A pin asks for service only when three conditions hold: its pending bit is set, it is unmasked, and its 4-bit priority field is non-zero. Software controls the block through a single-cycle register write port and a combinational read port. Pins are numbered from the most significant end in every register.

Each pin passes through a two-flop synchronizer into a small tracking state machine with two states. `DET_LOW` means the last synchronized sample was 0, and `DET_HIGH` means it was 1. The transition `DET_LOW -> DET_HIGH` is a rise, the transition `DET_HIGH -> DET_LOW` is a fall, and otherwise the state holds. The current state and the incoming sample together give the edge and level conditions. A mode bit selects how requests leave the block. In individual mode, each pin drives its own line. In encoded mode, the block presents the highest priority value among the requesting pins.

Top module: `extirq_ctrl`

## Requirements
- R1: Register select on `bus_addr`: 0 sense, 1 priority, 2 pending source, 3 mask-set, 4 mask-clear, 5 mode. Reading 3, 4, 6 or 7 returns 0. In the per-pin bit registers (source, mask-set, mask-clear), pin k sits at bit BIT_REG_W-1-k, so pin 0 is bit 7 with the default 8-bit width. `irq_o[k]` belongs to pin k.
- R2: Pin k's sense field occupies bits [32-(k+1)*SENSE_W +: SENSE_W]. The codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 both edges. Any other code detects nothing.
- R3: Pins are synchronized by two flops. A pin change applied between clock edges sets the pending bit on the third following rising edge. The pending bit rises only after a detection in the previous cycle.
- R4: In a level mode the pending bit is set on every cycle in which the synchronized level is active. A clear written while the level is still active therefore leaves the bit set.
- R5: Writing the source register clears each pending bit written as 0 and keeps each bit written as 1. If a detection happens in the same cycle, the detection wins.
- R6: Writing 1 to a pin's mask-set bit masks that pin. Bits written as 0 have no effect.
- R7: Writing 1 to a pin's mask-clear bit unmasks that pin. Bits written as 0 have no effect.
- R8: Pin k's priority field is bits [28-4k +: 4]. A field value of 0 blocks the pin, and any non-zero value lets it through.
- R9: After reset, all pending bits are 0, all pins are masked, all priorities are 0, all sense fields are 0 (falling edge) and the mode bit is 0. Register reads return 0, and both outputs are 0.
- R10: When mode bit 23 is 1 (individual mode), `irq_o[k]` equals pending AND NOT masked AND priority non-zero, and `lvl_o` is 0.
- R11: When mode bit 23 is 0 (encoded mode), `irq_o` is all zero and `lvl_o` carries the largest priority value among the requesting pins, or 0 if no pin is requesting.
- R12: Outputs reflect a register write from the clock edge that accepts the write onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | NUM_PINS | Per-pin request lines (individual mode) |
| lvl_o | output | 4 | Highest requesting priority (encoded mode) |

## Verification
The bench builds the block with its default parameters: eight pins, 4-bit sense fields and 8-bit bit registers. With eight pins, the priority and sense fields fill all 32 bits, so the placement of the lowest fields is checked along with the highest. The 4-bit sense width makes the both-edges code and an unused code (7) reachable; neither is possible with 2-bit fields. The 8-bit register width puts pin 0 at bit 7, which checks the reversed bit mapping against a width other than 32.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int PRIO_W = 4;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        SEL_SENSE = 3'd0,
        SEL_PRIO  = 3'd1,
        SEL_SRC   = 3'd2,
        SEL_MSET  = 3'd3,
        SEL_MCLR  = 3'd4,
        SEL_MODE  = 3'd5
    } reg_sel_e;

    typedef enum logic [3:0] {
        SN_FALL = 4'd0,
        SN_RISE = 4'd1,
        SN_LOW  = 4'd2,
        SN_HIGH = 4'd3,
        SN_BOTH = 4'd4
    } sense_code_e;

    typedef enum logic {
        DET_LOW  = 1'b0,
        DET_HIGH = 1'b1
    } det_state_e;

endpackage

// File: rtl/extirq_pin_det.sv
module extirq_pin_det
    import extirq_pkg::*;
#(
    parameter int SENSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    input  logic [SENSE_W-1:0] sense_i,
    output logic               hit_o
);

    logic       sync1_q;
    logic       sync2_q;
    det_state_e st_q;
    det_state_e st_nx;
    logic [3:0] code;
    logic       rose;
    logic       fell;

    // two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DET_LOW;
        else        st_q <= st_nx;
    end

    // next-state logic: rise and fall transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            DET_LOW:  if (sync2_q)  st_nx = DET_HIGH;
            DET_HIGH: if (!sync2_q) st_nx = DET_LOW;
        endcase
    end

    // output logic: detection per sense code
    always_comb begin
        code = 4'(sense_i);
        rose = (st_q == DET_LOW) && sync2_q;
        fell = (st_q == DET_HIGH) && !sync2_q;
        case (code)
            SN_FALL: hit_o = fell;
            SN_RISE: hit_o = rose;
            SN_LOW:  hit_o = !sync2_q;
            SN_HIGH: hit_o = sync2_q;
            SN_BOTH: hit_o = rose || fell;
            default: hit_o = 1'b0;
        endcase
    end

    // R2: a falling-edge hit leaves the tracker in the low state
    p_fall_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code == SN_FALL && hit_o) |=> (st_q == DET_LOW));

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_PINS  = 8,
    parameter int SENSE_W   = 4,
    parameter int BIT_REG_W = 8,
    parameter int MODE_BIT  = 23
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [2:0]                   addr_i,
    input  logic [WORD_W-1:0]            wdata_i,
    input  logic [NUM_PINS-1:0]          hit_i,
    output logic [WORD_W-1:0]            rdata_o,
    output logic [NUM_PINS*SENSE_W-1:0]  sense_o,
    output logic [NUM_PINS*PRIO_W-1:0]   prio_o,
    output logic [NUM_PINS-1:0]          pend_o,
    output logic [NUM_PINS-1:0]          mask_o,
    output logic                         indiv_o
);

    logic [WORD_W-1:0]   sense_q;
    logic [WORD_W-1:0]   prio_q;
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] mask_q;
    logic                mode_q;
    logic [NUM_PINS-1:0] wbit;
    logic                wr_sense, wr_prio, wr_src, wr_mset, wr_mclr, wr_mode;

    // pin k at bit BIT_REG_W-1-k; fields from the top of the word down
    for (genvar k = 0; k < NUM_PINS; k++) begin : g_map
        assign wbit[k] = wdata_i[BIT_REG_W-1-k];
        assign sense_o[k*SENSE_W +: SENSE_W] = sense_q[WORD_W-(k+1)*SENSE_W +: SENSE_W];
        assign prio_o[k*PRIO_W +: PRIO_W]    = prio_q[WORD_W-(k+1)*PRIO_W +: PRIO_W];
    end

    assign wr_sense = wr_i && (addr_i == SEL_SENSE);
    assign wr_prio  = wr_i && (addr_i == SEL_PRIO);
    assign wr_src   = wr_i && (addr_i == SEL_SRC);
    assign wr_mset  = wr_i && (addr_i == SEL_MSET);
    assign wr_mclr  = wr_i && (addr_i == SEL_MCLR);
    assign wr_mode  = wr_i && (addr_i == SEL_MODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            prio_q  <= '0;
            mode_q  <= 1'b0;
        end else begin
            if (wr_sense) sense_q <= wdata_i;
            if (wr_prio)  prio_q  <= wdata_i;
            if (wr_mode)  mode_q  <= wdata_i[MODE_BIT];
        end
    end

    // pending: zeros written clear, detection in the same cycle wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pend_q <= '0;
        else if (wr_src) pend_q <= (pend_q & wbit) | hit_i;
        else             pend_q <= pend_q | hit_i;
    end

    // mask: separate set and clear strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_mset) mask_q <= mask_q | wbit;
        else if (wr_mclr) mask_q <= mask_q & ~wbit;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            SEL_SENSE: rdata_o = sense_q;
            SEL_PRIO:  rdata_o = prio_q;
            SEL_SRC: begin
                for (int k = 0; k < NUM_PINS; k++)
                    rdata_o[BIT_REG_W-1-k] = pend_q[k];
            end
            SEL_MODE:  rdata_o[MODE_BIT] = mode_q;
            default:   rdata_o = '0;
        endcase
    end

    assign pend_o  = pend_q;
    assign mask_o  = mask_q;
    assign indiv_o = mode_q;

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_chk
        // R6: a one written to mask-set masks the pin
        p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == SEL_MSET && wdata_i[BIT_REG_W-1-k]) |=> mask_o[k]);
        // R7: a one written to mask-clear unmasks the pin
        p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == SEL_MCLR && wdata_i[BIT_REG_W-1-k]) |=> !mask_o[k]);
        // R5: a zero written to source with no detection clears the pin
        p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == SEL_SRC && !wdata_i[BIT_REG_W-1-k] && !hit_i[k])
            |=> !pend_o[k]);
    end

endmodule

// File: rtl/extirq_out.sv
module extirq_out
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0]        pend_i,
    input  logic [NUM_PINS-1:0]        mask_i,
    input  logic [NUM_PINS*PRIO_W-1:0] prio_i,
    input  logic                       indiv_i,
    output logic [NUM_PINS-1:0]        irq_o,
    output logic [PRIO_W-1:0]          lvl_o
);

    logic [NUM_PINS-1:0] req;
    logic [PRIO_W-1:0]   best;

    always_comb begin
        best = '0;
        for (int k = 0; k < NUM_PINS; k++) begin
            req[k] = pend_i[k] && !mask_i[k] && (prio_i[k*PRIO_W +: PRIO_W] != '0);
            if (req[k] && (prio_i[k*PRIO_W +: PRIO_W] > best))
                best = prio_i[k*PRIO_W +: PRIO_W];
        end
        irq_o = indiv_i ? req : '0;
        lvl_o = indiv_i ? '0 : best;
    end

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_PINS  = 8,
    parameter int SENSE_W   = 4,
    parameter int BIT_REG_W = 8,
    parameter int MODE_BIT  = 23
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_wr,
    input  logic [2:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_o,
    output logic [3:0]          lvl_o
);

    logic [NUM_PINS-1:0]         hit;
    logic [NUM_PINS*SENSE_W-1:0] sense;
    logic [NUM_PINS*PRIO_W-1:0]  prio;
    logic [NUM_PINS-1:0]         pend;
    logic [NUM_PINS-1:0]         mask;
    logic                        indiv;

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_det
        extirq_pin_det #(.SENSE_W(SENSE_W)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[k]),
            .sense_i (sense[k*SENSE_W +: SENSE_W]),
            .hit_o   (hit[k])
        );
    end

    extirq_regs #(
        .NUM_PINS  (NUM_PINS),
        .SENSE_W   (SENSE_W),
        .BIT_REG_W (BIT_REG_W),
        .MODE_BIT  (MODE_BIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .hit_i   (hit),
        .rdata_o (bus_rdata),
        .sense_o (sense),
        .prio_o  (prio),
        .pend_o  (pend),
        .mask_o  (mask),
        .indiv_o (indiv)
    );

    extirq_out #(.NUM_PINS(NUM_PINS)) u_out (
        .pend_i  (pend),
        .mask_i  (mask),
        .prio_i  (prio),
        .indiv_i (indiv),
        .irq_o   (irq_o),
        .lvl_o   (lvl_o)
    );

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_top_chk
        // R3: a pending bit only rises after a detection
        p_pend_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[k]) |-> $past(hit[k]));
    end

    // R11: a non-zero encoded level needs an unmasked pending pin
    p_lvl_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o != 4'd0) |-> ((pend & ~mask) != '0));

endmodule

// File: tb/sim_extirq_ctrl.sv
module sim_extirq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin = 8'hFF;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq;
    logic [3:0]  lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [31:0] sn = '0;

    always #5 clk = ~clk;

    extirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .lvl_o(lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [2:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); chk("R9 sense", d, 0);
        rd(3'd1, d); chk("R9 prio", d, 0);
        rd(3'd2, d); chk("R9 source", d, 0);
        rd(3'd5, d); chk("R9 mode", d, 0);
        rd(3'd7, d); chk("R1 unused addr", d, 0);
        chk("R9 irq", irq, 0);
        chk("R9 lvl", lvl, 0);
    endtask

    task automatic t_setup();
        logic [31:0] d;
        put(3'd5, 32'h0080_0000);
        put(3'd1, 32'hFFFF_FFFF);
        put(3'd2, 32'h0000_00FF);
        settle(2);
        chk("R9 all masked", irq, 0);
        put(3'd4, 32'h0000_00FF);
        settle(3);
        chk("R10 idle no irq", irq, 0);
        chk("R10 lvl zero", lvl, 0);
        rd(3'd5, d); chk("R1 mode readback", d, 32'h0080_0000);
    endtask

    task automatic t_fall();
        logic [31:0] d;
        pin[0] = 1'b0;
        settle(2);
        chk("R3 not yet", irq, 0);
        settle(1);
        chk("R3 fall pin0", irq, 8'h01);
        rd(3'd2, d); chk("R1 pin0 at bit7", d, 32'h80);
    endtask

    task automatic t_clear();
        put(3'd2, 32'hFF);
        chk("R5 ones keep", irq, 8'h01);
        put(3'd2, 32'h7F);
        chk("R5 zero clears", irq, 0);
        settle(3);
        chk("R5 edge not repeat", irq, 0);
    endtask

    task automatic t_rise();
        sn[27:24] = 4'd1; put(3'd0, sn);
        pin[1] = 1'b0; settle(4);
        chk("R2 rise ignores fall", irq, 0);
        pin[1] = 1'b1; settle(3);
        chk("R2 rise pin1", irq, 8'h02);
        put(3'd2, 32'h0);
        chk("R5 all zero clear", irq, 0);
    endtask

    task automatic t_level_low();
        sn[23:20] = 4'd2; put(3'd0, sn);
        pin[2] = 1'b0; settle(3);
        chk("R2 low level", irq, 8'h04);
        put(3'd2, 32'h0);
        chk("R4 re-set after clear", irq, 8'h04);
        pin[2] = 1'b1; settle(3);
        put(3'd2, 32'h0);
        chk("R4 released clears", irq, 0);
    endtask

    task automatic t_level_high();
        sn[19:16] = 4'd3; put(3'd0, sn);
        settle(1);
        chk("R2 high level", irq, 8'h08);
        pin[3] = 1'b0; settle(3);
        put(3'd2, 32'h0);
        chk("R4 high released", irq, 0);
    endtask

    task automatic t_both();
        sn[15:12] = 4'd4; put(3'd0, sn);
        pin[4] = 1'b0; settle(3);
        chk("R2 both fall", irq, 8'h10);
        put(3'd2, 32'h0);
        pin[4] = 1'b1; settle(3);
        chk("R2 both rise", irq, 8'h10);
        put(3'd2, 32'h0);
        chk("R5 both cleared", irq, 0);
    endtask

    task automatic t_badcode();
        logic [31:0] d;
        sn[11:8] = 4'd7; put(3'd0, sn);
        pin[5] = 1'b0; settle(3);
        pin[5] = 1'b1; settle(3);
        chk("R2 code 7 no irq", irq, 0);
        rd(3'd2, d); chk("R2 code 7 no pending", d, 0);
        rd(3'd0, d); chk("R2 sense readback", d, sn);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        put(3'd3, 32'h80);
        pin[0] = 1'b1; settle(3);
        pin[0] = 1'b0; settle(3);
        chk("R6 masked", irq, 0);
        rd(3'd2, d); chk("R6 pending kept", d, 32'h80);
        put(3'd3, 32'h00);
        chk("R6 zero no effect", irq, 0);
        put(3'd4, 32'h00);
        chk("R7 zero no effect", irq, 0);
        put(3'd4, 32'h80);
        chk("R12 unmask same edge", irq, 8'h01);
        put(3'd3, 32'h7F);
        chk("R6 zero keeps pin0", irq, 8'h01);
        rd(3'd3, d); chk("R1 mask-set reads 0", d, 0);
        rd(3'd4, d); chk("R1 mask-clear reads 0", d, 0);
        put(3'd4, 32'hFF);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        put(3'd1, 32'h0FFF_FFFF);
        chk("R8 prio zero blocks", irq, 0);
        rd(3'd2, d); chk("R8 pending stays", d, 32'h80);
        put(3'd1, 32'h1FFF_FFFF);
        chk("R8 prio one passes", irq, 8'h01);
        rd(3'd1, d); chk("R8 prio readback", d, 32'h1FFF_FFFF);
    endtask

    task automatic t_encoded();
        pin[1] = 1'b0; settle(3);
        pin[1] = 1'b1; settle(3);
        put(3'd1, 32'h5900_0000);
        chk("R10 two lines", irq, 8'h03);
        chk("R10 lvl zero", lvl, 0);
        put(3'd5, 32'h0);
        chk("R11 lines off", irq, 0);
        chk("R11 max prio", lvl, 4'd9);
        put(3'd3, 32'h40);
        chk("R11 masked drops", lvl, 4'd5);
        put(3'd1, 32'h0);
        chk("R11 none requesting", lvl, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_setup();
        t_fall();
        t_clear();
        t_rise();
        t_level_low();
        t_level_high();
        t_both();
        t_badcode();
        t_mask();
        t_prio();
        t_encoded();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule